// File: doc/BRIEF.md
# 16-bit Rotating ALU with Dual Add Overflow

This block is a purely combinational 16-bit arithmetic and logic unit for a small load-store processor datapath. Two operands and a 3-bit operation select go in. A 16-bit result and two overflow indications come out in the same cycle. The six operations are three bitwise logic functions, a two's-complement add, a pass-through of the second operand, and a right rotation of the first operand.

The rotate amount is taken from the low four bits of the second operand. The processor uses the pass-through path to load immediates and the add path to compute addresses. The two overflow outputs report the unsigned carry and the signed overflow of the add. They are forced low for every other operation. Callers decide which indication they act on.

Internally, a decoder turns the operation select into a one-hot set of path strobes. A datapath computes every candidate and merges them under those strobes.

Top module: `alu16Rot`

## Requirements
- R1: Select 3'b000 gives A AND B, 3'b001 gives A OR B, and 3'b010 gives A XOR B, bit by bit.
- R2: Select 3'b011 gives A + B modulo 2^16.
- R3: During an add (3'b011), `carryOut` is high exactly when the unsigned sum A + B exceeds 16'hFFFF.
- R4: During an add (3'b011), `signedOvf` is high exactly when A and B have the same bit 15 and the bit 15 of the sum differs from it.
- R5: Select 3'b100 returns B unchanged.
- R6: Select 3'b101 returns A rotated right by B[3:0] positions: result bit i equals A bit (i + B[3:0]) mod 16. B[15:4] has no effect.
- R7: A rotate amount of zero returns A unchanged.
- R8: Selects 3'b110 and 3'b111 give a zero result, with both overflow outputs low.
- R9: For every select other than 3'b011, `carryOut` and `signedOvf` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 16 | First operand; the value that is rotated |
| opB | input | 16 | Second operand; the low four bits give the rotate amount |
| opSel | input | 3 | Operation select |
| result | output | 16 | Operation result |
| signedOvf | output | 1 | Two's-complement overflow of the add |
| carryOut | output | 1 | Carry out of bit 15 of the add |

## Verification
The block holds no state, so any fault is visible at the ports in the same cycle as the input that exposes it. Most faults are either a wrong strobe from the decoder or a wrong candidate in the datapath. A wrong strobe shows up as a result taken from the wrong operation, or as two results ORed together. It can also show up as overflow flags raised during a logic, pass, rotate or reserved operation. A wrong candidate shows up only under the select that picks it. For that reason the bench spends most of its vectors on the corner cases: rotate amounts 0 and 15 with upper B bits set, adds that cross the sign boundary in both directions, and the all-ones carry case.

// File: rtl/aluPkg.sv
package aluPkg;

  typedef enum logic [2:0] {
    OP_AND  = 3'b000,
    OP_OR   = 3'b001,
    OP_XOR  = 3'b010,
    OP_ADD  = 3'b011,
    OP_PASS = 3'b100,
    OP_ROT  = 3'b101
  } aluOp_e;

  // One strobe per datapath path; at most one is high.
  typedef struct packed {
    logic selAnd;
    logic selOr;
    logic selXor;
    logic selAdd;
    logic selPass;
    logic selRot;
  } aluStrobe_t;

endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
(
  input  logic [2:0] opSel,
  output aluStrobe_t strobes
);

  always_comb begin
    strobes = '0;
    case (opSel)
      OP_AND:  strobes.selAnd  = 1'b1;
      OP_OR:   strobes.selOr   = 1'b1;
      OP_XOR:  strobes.selXor  = 1'b1;
      OP_ADD:  strobes.selAdd  = 1'b1;
      OP_PASS: strobes.selPass = 1'b1;
      OP_ROT:  strobes.selRot  = 1'b1;
      default: strobes = '0;
    endcase
  end

  always_comb begin
    AST_STROBE_ONEHOT: assert ($onehot0(strobes)); // R8
    if (opSel[2:1] == 2'b11)
      AST_RESERVED_NO_STROBE: assert (strobes == '0); // R8
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobe_t       strobes,
  output logic [WIDTH-1:0] result,
  output logic             signedOvf,
  output logic             carryOut
);

  localparam int AMT_W = $clog2(WIDTH);
  localparam int MSB   = WIDTH - 1;

  logic [WIDTH:0]     sumWide;
  logic [WIDTH-1:0]   sumVal;
  logic [WIDTH-1:0]   rotVal;
  logic [AMT_W-1:0]   rotAmt;

  assign sumWide = {1'b0, opA} + {1'b0, opB};
  assign sumVal  = sumWide[WIDTH-1:0];
  assign rotAmt  = opB[AMT_W-1:0];

  // Each result bit picks its source bit; the index wraps modulo WIDTH
  // because WIDTH is a power of two, so amount 0 is a plain copy.
  for (genvar g = 0; g < WIDTH; g++) begin : gRot
    logic [AMT_W-1:0] srcIdx;
    assign srcIdx    = AMT_W'(g) + rotAmt;
    assign rotVal[g] = opA[srcIdx];
  end

  // AND-OR merge under one-hot strobes; no strobe gives zero.
  always_comb begin
    result = '0;
    if (strobes.selAnd)  result = result | (opA & opB);
    if (strobes.selOr)   result = result | (opA | opB);
    if (strobes.selXor)  result = result | (opA ^ opB);
    if (strobes.selAdd)  result = result | sumVal;
    if (strobes.selPass) result = result | opB;
    if (strobes.selRot)  result = result | rotVal;
  end

  assign carryOut  = strobes.selAdd & sumWide[WIDTH];
  assign signedOvf = strobes.selAdd & ~(opA[MSB] ^ opB[MSB]) & (sumVal[MSB] ^ opA[MSB]);

  always_comb begin
    if (!strobes.selAdd)
      AST_FLAGS_QUIET: assert (!signedOvf && !carryOut); // R9
    if (strobes.selAdd && carryOut)
      AST_CARRY_WRAPS: assert (result < opA); // R3
    if (strobes.selAdd && !carryOut)
      AST_NOCARRY_GROWS: assert (result >= opA); // R3
    if (strobes.selAdd && (opA[MSB] != opB[MSB]))
      AST_MIXED_SIGN_SAFE: assert (!signedOvf); // R4
    if (strobes.selPass)
      AST_PASS_B: assert (result == opB); // R5
    if (strobes.selRot)
      AST_ROT_KEEPS_ONES: assert ($countones(result) == $countones(opA)); // R6
  end

endmodule

// File: rtl/alu16Rot.sv
module alu16Rot
  import aluPkg::*;
(
  input  logic [15:0] opA,
  input  logic [15:0] opB,
  input  logic [2:0]  opSel,
  output logic [15:0] result,
  output logic        signedOvf,
  output logic        carryOut
);

  aluStrobe_t strobes;

  aluControl uCtrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  aluDatapath #(.WIDTH(16)) uPath (
    .opA       (opA),
    .opB       (opB),
    .strobes   (strobes),
    .result    (result),
    .signedOvf (signedOvf),
    .carryOut  (carryOut)
  );

  always_comb begin
    if (opSel[2:1] == 2'b11)
      AST_RESERVED_ZERO: assert (result == '0 && !signedOvf && !carryOut); // R8
  end

endmodule

// File: tb/sim_alu16Rot.sv
module sim_alu16Rot;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [2:0]  opSel = '0;
  logic [15:0] result;
  logic        signedOvf;
  logic        carryOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu16Rot u0 (
    .opA(opA), .opB(opB), .opSel(opSel),
    .result(result), .signedOvf(signedOvf), .carryOut(carryOut)
  );

  // Behavioural reference using integer arithmetic.
  task automatic refModel(input int a, input int b, input int op,
                          output int r, output int sv, output int cy);
    int sa, sb, s, amt;
    r = 0; sv = 0; cy = 0;
    case (op)
      0: r = a & b;
      1: r = a | b;
      2: r = a ^ b;
      3: begin
        r  = (a + b) % 65536;
        cy = (a + b > 65535) ? 1 : 0;
        sa = (a >= 32768) ? a - 65536 : a;
        sb = (b >= 32768) ? b - 65536 : b;
        s  = sa + sb;
        sv = (s > 32767 || s < -32768) ? 1 : 0;
      end
      4: r = b;
      5: begin
        amt = b % 16;
        r = ((a >> amt) | (a << (16 - amt))) & 32'hFFFF;
      end
      default: r = 0;
    endcase
  endtask

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h (A=%h B=%h op=%0d)",
               tag, act, exp, opA, opB, opSel);
    end
  endtask

  // Drive on a rising edge, sample at the following falling edge.
  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic [2:0] op);
    int er, es, ec;
    string rTag, fTag;
    @(posedge clk);
    opA = a; opB = b; opSel = op;
    @(negedge clk);
    refModel(int'(a), int'(b), int'(op), er, es, ec);
    case (op)
      3'd0, 3'd1, 3'd2: rTag = "R1";
      3'd3:             rTag = "R2";
      3'd4:             rTag = "R5";
      3'd5:             rTag = (b[3:0] == 4'd0) ? "R7" : "R6";
      default:          rTag = "R8";
    endcase
    fTag = (op == 3'd3) ? "" : ((op[2:1] == 2'b11) ? "R8" : "R9");
    check(rTag, int'(result), er);
    check((op == 3'd3) ? "R3" : fTag, int'(carryOut), ec);
    check((op == 3'd3) ? "R4" : fTag, int'(signedOvf), es);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    // Quiescent state: zero operands with the AND select (R1).
    @(negedge clk);
    check("R1", int'(result), 0);
    check("R9", int'(carryOut), 0);
    check("R9", int'(signedOvf), 0);

    // R1 logic patterns
    apply(16'hF0F0, 16'hFF00, 3'd0);
    apply(16'hF0F0, 16'hFF00, 3'd1);
    apply(16'hF0F0, 16'hFF00, 3'd2);
    // R2 / R3 / R4 add corners
    apply(16'hFFFF, 16'h0001, 3'd3);
    apply(16'h7FFF, 16'h0001, 3'd3);
    apply(16'h8000, 16'h8000, 3'd3);
    apply(16'h8000, 16'h7FFF, 3'd3);
    apply(16'hFFFF, 16'hFFFF, 3'd3);
    apply(16'h1234, 16'h4321, 3'd3);
    // R5 pass
    apply(16'hAAAA, 16'h5A5A, 3'd4);
    // R6 / R7 rotate, upper B bits set to show they are ignored
    apply(16'h8001, 16'hFFF0, 3'd5);
    apply(16'h8001, 16'h0001, 3'd5);
    apply(16'h8001, 16'hABCF, 3'd5);
    apply(16'h1234, 16'h0004, 3'd5);
    apply(16'h1234, 16'h5678, 3'd5);
    // R8 reserved selects with operands that would overflow an add
    apply(16'hFFFF, 16'hFFFF, 3'd6);
    apply(16'h8000, 16'h8000, 3'd7);
    // R9 flags quiet on non-add ops with overflowing operands
    apply(16'hFFFF, 16'hFFFF, 3'd1);
    apply(16'h8000, 16'h8000, 3'd4);
    // Mixed sweep over every select
    for (int i = 0; i < 400; i++) begin
      apply(16'($urandom), 16'($urandom), 3'(i % 8));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule